// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences one external memory bus cycle at a time. A cycle request is accepted only while the controller is idle. The controller then steps through an address phase, a run of wait phases and a single data phase, and it raises a ready strobe in the data phase so the bus interface can advance. For read cycles it can add a float phase at the end, during which the bus stays released before the next address is driven. This lengthens the dead time that slow memories need.

The number of wait states comes from a 2-bit active-low wait-state code. That code applies only when the access hits the controlled region; any other access gets no configured wait states. An active-low extended-float bit selects the lengthened read timing. When that timing is active, the wait-state count is also restricted to one or three. A configuration-fetch qualifier forces the extended timing for the boot-time configuration read.

Two further features each have their own enable. A real-time wait input can stretch the wait phase while it is held low. A wait clock output runs at half the controller clock rate.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all phase strobes, the ready strobe and the wait clock are low, even if the wait clock enable is high.
- R2: A start request is captured at a clock edge only while the controller is idle. The address phase is then high for exactly one cycle. It is followed by N wait-phase cycles and then one data-phase cycle, during which the ready strobe is high. Strobe code {addr, wait, data, float, ready}: idle 00000, address 10000, wait 01000, data 00101, float 00010.
- R3: On a region hit with extended float off (float bit 1, no configuration fetch), the wait-state code 11, 10, 01, 00 gives N = 0, 1, 2, 3.
- R4: On a region hit with extended float on (float bit 0), the code 11 or 10 gives N = 1, and the code 01 or 00 gives N = 3.
- R5: When the region-hit input is low, N = 0 whatever the wait-state code and float bit are.
- R6: When extended float is active, a read cycle gets exactly one float-phase cycle after its data phase. Write cycles, and all reads with extended float off, return to idle directly after the data phase.
- R7: A cycle started with the configuration-fetch input high uses the extended timing (R4 count and R6 float) even when the float bit is 1.
- R8: With the wait enable at 1 and N > 0, the wait input is sampled at the end of the last configured wait state and again at the end of each following wait state. While it samples low the wait phase continues. The data phase follows the first high sample. With N = 0 the wait input has no effect.
- R9: With the wait enable at 0, a low wait input does not lengthen the cycle.
- R10: A start request during a cycle in progress is ignored. Changes to the read/write input, the region hit, the wait-state code, the float bit or the configuration-fetch input after the start edge do not alter that cycle.
- R11: With the wait clock enable at 1, the wait clock inverts at every clock edge, giving a period of two clocks. With the enable at 0 it goes low at the next edge and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Request to begin a bus cycle |
| cyc_read | input | 1 | 1 = read cycle, 0 = write cycle |
| region_hit | input | 1 | Access falls in the controlled region |
| cfg_ws_n | input | 2 | Active-low wait-state code |
| cfg_float_n | input | 1 | Extended float select, 0 = enabled |
| cfg_fetch | input | 1 | Cycle is the configuration fetch, forces extended timing |
| wait_en | input | 1 | Enable for the real-time wait input |
| wait_n | input | 1 | Real-time wait input, low = stretch |
| wclk_en | input | 1 | Enable for the wait clock output |
| ph_addr | output | 1 | Address phase strobe |
| ph_wait | output | 1 | Wait phase strobe |
| ph_data | output | 1 | Data phase strobe |
| ph_float | output | 1 | Float phase strobe, bus released |
| cyc_ready | output | 1 | Ready/advance, high in the data phase |
| wclk | output | 1 | Wait clock output |

## Verification
The start request is captured at edge P1. The address strobe then appears in the cycle after P1, and the wait strobes fill the next N plus stretch cycles. The data and ready strobes follow in the cycle after that, and for an extended-float read the float strobe comes one cycle later. The driver pushes one expected strobe code per cycle, beginning with an idle code for the cycle in which the request is still uncaptured. The monitor pops one code at every falling edge, so each strobe is compared in the exact cycle it is due. The wait input is released one clock before the edge that must see it high. The wait clock is checked on consecutive falling edges, and after disabling it the checks expect low from the next edge on.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
// Package: shared phase encoding for the wait-state controller.
// Assumes one bus cycle in flight at a time.
package wsc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_WAIT  = 3'd2,
        PH_DATA  = 3'd3,
        PH_FLOAT = 3'd4
    } phase_t;
endpackage

// File: rtl/wsc_wait_calc.sv
`timescale 1ns/1ps
// Module: wsc_wait_calc
// Turns the active-low wait-state code into a wait count.
// Standard timing: count is the inverted code. Extended timing: the count is
// forced odd (1 or 3 for a 2-bit code). An access outside the region gets zero.
// Assumes a purely combinational use; the sequencer latches the result.
module wsc_wait_calc #(
    parameter int WS_W = 2
) (
    input  logic [WS_W-1:0] ws_n,
    input  logic            ext,
    input  logic            hit,
    output logic [WS_W-1:0] count
);
    localparam logic [WS_W-1:0] ODD_BIT = WS_W'(1);

    // Wait-count selection from code, timing mode and region hit.
    always_comb begin
        if (!hit)
            count = '0;
        else if (ext)
            count = ~ws_n | ODD_BIT;
        else
            count = ~ws_n;
    end

    // R4: extended timing on a hit never yields an even count.
    always_comb begin
        if (hit && ext)
            p_ext_odd_r4: assert (count[0] == 1'b1);
    end
endmodule

// File: rtl/wsc_phase_fsm.sv
`timescale 1ns/1ps
// Module: wsc_phase_fsm
// Sequences idle -> address -> waits -> data -> (float) -> idle.
// It latches the wait count, direction and timing mode at the start edge.
// The wait input can hold the last wait state when enabled.
// Assumes synchronous inputs; an asynchronous wait input must be synchronised upstream.
module wsc_phase_fsm
    import wsc_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_read,
    input  logic [CNT_W-1:0] ws_count,
    input  logic             ext,
    input  logic             wait_en,
    input  logic             wait_n,
    output phase_t           phase
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem;
    logic             lat_read;
    logic             lat_ext;
    logic             stretch;

    // Wait extension request from the real-time input.
    assign stretch = wait_en && !wait_n;

    // Phase state register with latched cycle attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            rem      <= '0;
            lat_read <= 1'b0;
            lat_ext  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (cyc_start) begin
                        phase    <= PH_ADDR;
                        rem      <= ws_count;
                        lat_read <= cyc_read;
                        lat_ext  <= ext;
                    end
                end
                PH_ADDR: phase <= (rem == '0) ? PH_DATA : PH_WAIT;
                PH_WAIT: begin
                    if (rem > ONE)
                        rem <= rem - ONE;
                    else if (!stretch)
                        phase <= PH_DATA;
                end
                PH_DATA:  phase <= (lat_read && lat_ext) ? PH_FLOAT : PH_IDLE;
                PH_FLOAT: phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R2: the address phase lasts one cycle and leads to a wait or data phase.
    p_addr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |=> (phase == PH_WAIT || phase == PH_DATA));

    // R6: an extended-timing read always passes through the float phase.
    p_float_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && lat_read && lat_ext) |=> (phase == PH_FLOAT));

    // R6: a write never gets a float phase.
    p_write_nofloat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !lat_read) |=> (phase == PH_IDLE));

    // R8: a low sample on the last wait state holds the wait phase.
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT && rem == ONE && wait_en && !wait_n) |=> (phase == PH_WAIT));

    // R10: no new address phase can begin except from idle.
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> (phase != PH_ADDR));
endmodule

// File: rtl/wsc_wclk_gen.sv
`timescale 1ns/1ps
// Module: wsc_wclk_gen
// Wait clock output: inverts every clock while enabled, held low otherwise.
// Assumes the output is consumed as a registered signal (period = two clocks).
module wsc_wclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wclk
);
    // Toggle flop gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wclk <= 1'b0;
        else
            wclk <= en ? ~wclk : 1'b0;
    end

    // R11: disabled wait clock is low at the next edge.
    p_wclk_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !wclk);

    // R11: enabled wait clock changes level at every edge.
    p_wclk_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (wclk != $past(wclk)));
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
`timescale 1ns/1ps
// Module: ext_bus_wait_ctrl
// Top of the external bus wait-state controller for one address region.
// Derives the wait count and timing mode, sequences the bus phases and
// drives the wait clock. Address decode and memory are outside this block.
module ext_bus_wait_ctrl
    import wsc_pkg::*;
#(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_start,
    input  logic            cyc_read,
    input  logic            region_hit,
    input  logic [WS_W-1:0] cfg_ws_n,
    input  logic            cfg_float_n,
    input  logic            cfg_fetch,
    input  logic            wait_en,
    input  logic            wait_n,
    input  logic            wclk_en,
    output logic            ph_addr,
    output logic            ph_wait,
    output logic            ph_data,
    output logic            ph_float,
    output logic            cyc_ready,
    output logic            wclk
);
    localparam int CNT_W = WS_W;

    logic             ext_mode;
    logic [CNT_W-1:0] ws_count;
    phase_t           phase;

    // Extended timing is selected by the low-active bit or by a configuration fetch.
    assign ext_mode = !cfg_float_n || cfg_fetch;

    wsc_wait_calc #(.WS_W(WS_W)) u_calc (
        .ws_n  (cfg_ws_n),
        .ext   (ext_mode),
        .hit   (region_hit),
        .count (ws_count)
    );

    wsc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_read  (cyc_read),
        .ws_count  (ws_count),
        .ext       (ext_mode),
        .wait_en   (wait_en),
        .wait_n    (wait_n),
        .phase     (phase)
    );

    wsc_wclk_gen u_wclk (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wclk_en),
        .wclk (wclk)
    );

    // Phase strobe decode.
    always_comb begin
        ph_addr  = (phase == PH_ADDR);
        ph_wait  = (phase == PH_WAIT);
        ph_data  = (phase == PH_DATA);
        ph_float = (phase == PH_FLOAT);
    end

    assign cyc_ready = ph_data;

    // R2: at most one phase strobe is active in any cycle.
    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_addr, ph_wait, ph_data, ph_float}));

    // R2: ready follows a wait or address phase.
    p_ready_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_ready) |-> ($past(ph_wait) || $past(ph_addr)));
endmodule

// File: tb/ext_bus_wait_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes one expected strobe code per cycle,
// and the monitor pops and compares one code at every falling edge.
module ext_bus_wait_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, cyc_read = 1'b0, region_hit = 1'b0;
    logic [1:0] cfg_ws_n = 2'b11;
    logic cfg_float_n = 1'b1, cfg_fetch = 1'b0;
    logic wait_en = 1'b0, wait_n = 1'b1, wclk_en = 1'b0;
    logic ph_addr, ph_wait, ph_data, ph_float, cyc_ready, wclk;

    int checks = 0;
    int fails = 0;
    logic [4:0] exp_q[$];
    string      tag_q[$];

    localparam logic [4:0] C_IDLE  = 5'b00000;
    localparam logic [4:0] C_ADDR  = 5'b10000;
    localparam logic [4:0] C_WAIT  = 5'b01000;
    localparam logic [4:0] C_DATA  = 5'b00101;
    localparam logic [4:0] C_FLOAT = 5'b00010;

    always #10 clk = ~clk;

    ext_bus_wait_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_read(cyc_read),
        .region_hit(region_hit), .cfg_ws_n(cfg_ws_n), .cfg_float_n(cfg_float_n),
        .cfg_fetch(cfg_fetch), .wait_en(wait_en), .wait_n(wait_n), .wclk_en(wclk_en),
        .ph_addr(ph_addr), .ph_wait(ph_wait), .ph_data(ph_data), .ph_float(ph_float),
        .cyc_ready(cyc_ready), .wclk(wclk)
    );

    task automatic check(string tag, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // Monitor: compare strobes against the scoreboard once per cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {ph_addr, ph_wait, ph_data, ph_float, cyc_ready}, e);
        end
    end

    function automatic int exp_waits(bit hit, bit [1:0] ws, bit ext);
        if (!hit) return 0;
        if (ext) begin
            case (ws)
                2'b11, 2'b10: return 1;
                default:      return 3;
            endcase
        end
        case (ws)
            2'b11:   return 0;
            2'b10:   return 1;
            2'b01:   return 2;
            default: return 3;
        endcase
    endfunction

    task automatic push(string tag, logic [4:0] c);
        exp_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    // Driver: one bus cycle; s = cycles the wait input is held low past the
    // configured waits; poke = repeat start and change config mid-cycle.
    task automatic run_cyc(string tag, bit rd, bit hit, bit [1:0] ws, bit fl,
                           bit fetch, bit wen, int s, bit poke);
        int n;
        int st;
        bit ext;
        ext = !fl || fetch;
        n  = exp_waits(hit, ws, ext);
        st = (wen && n > 0) ? s : 0;
        @(posedge clk); #1;
        cyc_read = rd; region_hit = hit; cfg_ws_n = ws; cfg_float_n = fl;
        cfg_fetch = fetch; wait_en = wen; wait_n = (s > 0) ? 1'b0 : 1'b1;
        cyc_start = 1'b1;
        push(tag, C_IDLE);
        push(tag, C_ADDR);
        for (int i = 0; i < n + st; i++) push(tag, C_WAIT);
        push(tag, C_DATA);
        if (rd && ext) push(tag, C_FLOAT);
        @(posedge clk); #1;
        if (poke) begin
            cfg_ws_n = ~ws; cyc_read = ~rd; cfg_float_n = ~fl;
            region_hit = ~hit; cfg_fetch = ~fetch;
            @(posedge clk); #1;
        end
        cyc_start = 1'b0;
        if (s > 0) begin
            repeat (n + s) @(posedge clk);
            #1 wait_n = 1'b1;
        end
        while (exp_q.size() > 0) @(negedge clk);
        wait_n = 1'b1; wait_en = 1'b0; cfg_fetch = 1'b0; cyc_start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        // R1: reset state, wait clock enable held high during reset.
        wclk_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 strobes", {ph_addr, ph_wait, ph_data, ph_float, cyc_ready}, C_IDLE);
        check("R1 wclk", {4'b0, wclk}, 5'b0);
        wclk_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {ph_addr, ph_wait, ph_data, ph_float, cyc_ready, wclk} >> 1, 5'b0);

        // R2/R3: standard mapping on a hit.
        run_cyc("R2 R3 ws11 read", 1, 1, 2'b11, 1, 0, 0, 0, 0);
        run_cyc("R3 ws10 write",   0, 1, 2'b10, 1, 0, 0, 0, 0);
        run_cyc("R3 ws01 read",    1, 1, 2'b01, 1, 0, 0, 0, 0);
        run_cyc("R3 ws00 write",   0, 1, 2'b00, 1, 0, 0, 0, 0);
        // R4: extended mapping, writes.
        run_cyc("R4 ws11 write",   0, 1, 2'b11, 0, 0, 0, 0, 0);
        run_cyc("R4 ws10 write",   0, 1, 2'b10, 0, 0, 0, 0, 0);
        run_cyc("R4 ws01 write",   0, 1, 2'b01, 0, 0, 0, 0, 0);
        run_cyc("R4 ws00 write",   0, 1, 2'b00, 0, 0, 0, 0, 0);
        // R6: float phase only for extended reads.
        run_cyc("R6 ext read ws10", 1, 1, 2'b10, 0, 0, 0, 0, 0);
        run_cyc("R6 std read ws01", 1, 1, 2'b01, 1, 0, 0, 0, 0);
        // R5: region miss.
        run_cyc("R5 miss std",      0, 0, 2'b00, 1, 0, 0, 0, 0);
        run_cyc("R5 miss ext read", 1, 0, 2'b00, 0, 0, 0, 0, 0);
        // R7: configuration fetch forces extended timing.
        run_cyc("R7 fetch read ws01", 1, 1, 2'b01, 1, 1, 0, 0, 0);
        // R8: stretch by the wait input when enabled.
        run_cyc("R8 stretch 3",      1, 1, 2'b10, 1, 0, 1, 3, 0);
        run_cyc("R8 stretch 1 ext",  1, 1, 2'b00, 0, 0, 1, 1, 0);
        run_cyc("R8 zero waits",     0, 1, 2'b11, 1, 0, 1, 2, 0);
        // R9: wait input ignored when disabled.
        run_cyc("R9 wait disabled",  0, 1, 2'b10, 1, 0, 0, 3, 0);
        // R10: repeated start and mid-cycle config changes ignored.
        run_cyc("R10 poke ws10 write", 0, 1, 2'b10, 1, 0, 0, 0, 1);
        run_cyc("R10 poke ws11 read",  1, 1, 2'b11, 1, 0, 0, 0, 1);

        // R11: wait clock toggling and disable.
        @(posedge clk); #1 wclk_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R11 toggle", {4'b0, wclk}, {4'b0, 1'(i % 2)});
        end
        wclk_en = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R11 disabled low", {4'b0, wclk}, 5'b0);
        end

        report();
        $finish;
    end
endmodule